// File: doc/BRIEF.md
# Dual-FIFO Byte-Wide Host Data Port

This block takes audio data from a host one byte at a time and sorts it into two first-in first-out buffers: one for compressed audio and one for PCM samples. On each write strobe the host presents a 2-bit address and a data byte. The address picks the target buffer. Each buffer has a downstream valid/ready byte interface that drains one byte per handshake.

Each buffer drives a "busy" indicator that depends only on its current occupancy. The indicator is low while the free space is at least one full block, where the block size comes from an input. The host samples the indicator once before each block and then sends the whole block. The indicator may go high partway through a block, but the remaining bytes of that block still fit.

For the compressed buffer, the indicator also appears on a separate request pin. In strobe mode, compressed bytes come from a separate set of data pins instead of the host bus. Each byte is captured on a rising edge of a dedicated capture clock input, which is synchronised into the system clock domain.

Top module: `host_byte_port`

## Requirements
- R1: With `strobe_mode` low, a host write with address 2'b11 pushes `host_data` into the compressed buffer, and the bytes come out of `cmp_rd_data` in write order.
- R2: A host write with address 2'b10 pushes `host_data` into the PCM buffer. Writes with address 2'b00 or 2'b01 push into neither buffer.
- R3: `cmp_busy` is high exactly when the compressed buffer occupancy plus `cmp_block` exceeds DEPTH. It follows the occupancy in the cycle after each push or pop, even in the middle of a block.
- R4: `cmp_req` carries the same value as `cmp_busy` in every cycle.
- R5: `pcm_busy` is high exactly when the PCM buffer occupancy plus `pcm_block` exceeds DEPTH.
- R6: With `strobe_mode` high, each rising edge of `cap_clk` pushes `cap_data` into the compressed buffer. Holding `cap_clk` high pushes nothing further, and host writes to address 2'b11 are ignored.
- R7: A push into a full buffer (occupancy DEPTH) is dropped and the buffer is left unchanged, even if a pop happens in the same cycle. The drop sets that buffer's overflow flag (`cmp_ovf` or `pcm_ovf`), which stays high until reset.
- R8: `*_rd_valid` is high while the buffer holds data, and `*_rd_data` is the oldest byte. A cycle with valid and ready high removes that byte. While valid is high and ready is low, the data stays unchanged.
- R9: After synchronous reset, both buffers are empty, both overflow flags are low and both valid outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, one byte per cycle |
| host_addr | input | 2 | Target select: 11 compressed, 10 PCM, 0x none |
| host_data | input | 8 | Host data byte |
| strobe_mode | input | 1 | Compressed bytes come from the capture pins |
| cap_clk | input | 1 | Capture clock, rising edge takes a byte |
| cap_data | input | 8 | Capture data pins |
| cmp_block | input | CW | Compressed block size in bytes |
| pcm_block | input | CW | PCM block size in bytes |
| cmp_busy | output | 1 | Compressed status bit, low means a block fits |
| cmp_req | output | 1 | Compressed request pin, same value as cmp_busy |
| pcm_busy | output | 1 | PCM status bit, low means a block fits |
| cmp_ovf | output | 1 | Sticky compressed overflow flag |
| pcm_ovf | output | 1 | Sticky PCM overflow flag |
| cmp_rd_valid | output | 1 | Compressed byte available |
| cmp_rd_ready | input | 1 | Consumer takes a compressed byte |
| cmp_rd_data | output | 8 | Oldest compressed byte |
| pcm_rd_valid | output | 1 | PCM byte available |
| pcm_rd_ready | input | 1 | Consumer takes a PCM byte |
| pcm_rd_data | output | 8 | Oldest PCM byte |

## Verification
The bench builds the block with DEPTH set to 8, so CW is 4. At that depth, every pairing of occupancy 0 to 8 with block sizes 0 to 9 can be swept for both indicators and compared with the arithmetic rule. The small depth also lets a few writes fill a buffer, so the full-buffer drop, the sticky overflow flag and the in-order drain of a full buffer are each tested directly. Strobe mode is tested with single capture edges and with a held-high capture clock.

// File: rtl/hbp_pkg.sv
package hbp_pkg;

    localparam int BYTE_W = 8;

    typedef logic [BYTE_W-1:0] byte_t;

    typedef enum logic [1:0] {
        SEL_IDLE0 = 2'b00,
        SEL_IDLE1 = 2'b01,
        SEL_PCM   = 2'b10,
        SEL_CMP   = 2'b11
    } port_sel_e;

    typedef struct packed {
        logic  push;
        byte_t data;
    } push_t;

    // Advance a ring index, wrapping after the last slot.
    function automatic int unsigned ring_next(int unsigned idx, int unsigned depth);
        return (idx == depth - 1) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/hbp_decode.sv
module hbp_decode
    import hbp_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_wr,
    input  logic [1:0] host_addr,
    input  byte_t      host_data,
    input  logic       strobe_mode,
    input  logic       cap_clk,
    input  byte_t      cap_data,
    output push_t      cmp_push,
    output push_t      pcm_push
);

    logic [SYNC_STAGES:0] cap_sync;
    logic                 cap_edge;
    port_sel_e            sel;

    always_ff @(posedge clk) begin
        if (rst) cap_sync <= '0;
        else     cap_sync <= {cap_sync[SYNC_STAGES-1:0], cap_clk};
    end

    assign cap_edge = cap_sync[SYNC_STAGES-1] & ~cap_sync[SYNC_STAGES];
    assign sel      = port_sel_e'(host_addr);

    always_comb begin
        if (strobe_mode) begin
            cmp_push.push = cap_edge;
            cmp_push.data = cap_data;
        end else begin
            cmp_push.push = host_wr && (sel == SEL_CMP);
            cmp_push.data = host_data;
        end
        pcm_push.push = host_wr && (sel == SEL_PCM);
        pcm_push.data = host_data;
    end

endmodule

// File: rtl/hbp_fifo.sv
module hbp_fifo
    import hbp_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  push_t         wr,
    input  logic [CW-1:0] block,
    output logic          rd_valid,
    input  logic          rd_ready,
    output byte_t         rd_data,
    output logic          busy,
    output logic          ovf,
    output logic [CW-1:0] count
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    byte_t         mem [DEPTH];
    logic [PW-1:0] wr_ptr, rd_ptr;
    logic          full, do_push, do_pop;

    assign full     = (count == CW'(DEPTH));
    assign rd_valid = (count != '0);
    assign do_push  = wr.push && !full;
    assign do_pop   = rd_valid && rd_ready;
    assign rd_data  = mem[rd_ptr];
    assign busy     = ({1'b0, count} + {1'b0, block}) > (CW+1)'(DEPTH);

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= wr.data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
        end else begin
            if (do_push) wr_ptr <= PW'(ring_next(int'(wr_ptr), DEPTH));
            if (do_pop)  rd_ptr <= PW'(ring_next(int'(rd_ptr), DEPTH));
            if (do_push && !do_pop)      count <= count + 1'b1;
            else if (!do_push && do_pop) count <= count - 1'b1;
            if (wr.push && full) ovf <= 1'b1;
        end
    end

endmodule

// File: rtl/host_byte_port.sv
module host_byte_port
    import hbp_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          host_wr,
    input  logic [1:0]    host_addr,
    input  logic [7:0]    host_data,
    input  logic          strobe_mode,
    input  logic          cap_clk,
    input  logic [7:0]    cap_data,
    input  logic [CW-1:0] cmp_block,
    input  logic [CW-1:0] pcm_block,
    output logic          cmp_busy,
    output logic          cmp_req,
    output logic          pcm_busy,
    output logic          cmp_ovf,
    output logic          pcm_ovf,
    output logic          cmp_rd_valid,
    input  logic          cmp_rd_ready,
    output logic [7:0]    cmp_rd_data,
    output logic          pcm_rd_valid,
    input  logic          pcm_rd_ready,
    output logic [7:0]    pcm_rd_data
);

    localparam int NCH    = 2;
    localparam int CH_CMP = 0;
    localparam int CH_PCM = 1;

    push_t         ch_push  [NCH];
    logic [CW-1:0] ch_block [NCH];
    logic [CW-1:0] ch_count [NCH];
    logic          ch_ready [NCH];
    logic          ch_valid [NCH];
    byte_t         ch_data  [NCH];
    logic          ch_busy  [NCH];
    logic          ch_ovf   [NCH];
    logic [CW-1:0] cmp_cnt, pcm_cnt;

    hbp_decode u_dec (
        .clk        (clk),
        .rst        (rst),
        .host_wr    (host_wr),
        .host_addr  (host_addr),
        .host_data  (host_data),
        .strobe_mode(strobe_mode),
        .cap_clk    (cap_clk),
        .cap_data   (cap_data),
        .cmp_push   (ch_push[CH_CMP]),
        .pcm_push   (ch_push[CH_PCM])
    );

    assign ch_block[CH_CMP] = cmp_block;
    assign ch_block[CH_PCM] = pcm_block;
    assign ch_ready[CH_CMP] = cmp_rd_ready;
    assign ch_ready[CH_PCM] = pcm_rd_ready;

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        hbp_fifo #(.DEPTH(DEPTH), .CW(CW)) u_fifo (
            .clk     (clk),
            .rst     (rst),
            .wr      (ch_push[g]),
            .block   (ch_block[g]),
            .rd_valid(ch_valid[g]),
            .rd_ready(ch_ready[g]),
            .rd_data (ch_data[g]),
            .busy    (ch_busy[g]),
            .ovf     (ch_ovf[g]),
            .count   (ch_count[g])
        );
    end

    assign cmp_busy     = ch_busy[CH_CMP];
    assign cmp_req      = ch_busy[CH_CMP];
    assign pcm_busy     = ch_busy[CH_PCM];
    assign cmp_ovf      = ch_ovf[CH_CMP];
    assign pcm_ovf      = ch_ovf[CH_PCM];
    assign cmp_rd_valid = ch_valid[CH_CMP];
    assign cmp_rd_data  = ch_data[CH_CMP];
    assign pcm_rd_valid = ch_valid[CH_PCM];
    assign pcm_rd_data  = ch_data[CH_PCM];
    assign cmp_cnt      = ch_count[CH_CMP];
    assign pcm_cnt      = ch_count[CH_PCM];

endmodule

// File: rtl/hbp_port_checker.sv
module hbp_port_checker #(
    parameter int DEPTH = 64,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst,
    input logic          host_wr,
    input logic [1:0]    host_addr,
    input logic [CW-1:0] cmp_block,
    input logic [CW-1:0] pcm_block,
    input logic          cmp_busy,
    input logic          pcm_busy,
    input logic          cmp_ovf,
    input logic          pcm_ovf,
    input logic          cmp_rd_valid,
    input logic          cmp_rd_ready,
    input logic [7:0]    cmp_rd_data,
    input logic          pcm_rd_valid,
    input logic          pcm_rd_ready,
    input logic [7:0]    pcm_rd_data,
    input logic [CW-1:0] cmp_cnt,
    input logic [CW-1:0] pcm_cnt
);

    p_ignore_r2: assert property (@(posedge clk) disable iff (rst)
        (host_wr && !host_addr[1] && !(pcm_rd_valid && pcm_rd_ready)) |=> $stable(pcm_cnt));

    p_room_r3: assert property (@(posedge clk) disable iff (rst)
        !cmp_busy |-> (DEPTH - int'(cmp_cnt)) >= int'(cmp_block));

    p_room_r5: assert property (@(posedge clk) disable iff (rst)
        !pcm_busy |-> (DEPTH - int'(pcm_cnt)) >= int'(pcm_block));

    p_full_drop_r7: assert property (@(posedge clk) disable iff (rst)
        (cmp_cnt == CW'(DEPTH) && !(cmp_rd_valid && cmp_rd_ready)) |=> cmp_cnt == CW'(DEPTH));

    p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        cmp_ovf |=> cmp_ovf);

    p_pcm_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        pcm_ovf |=> pcm_ovf);

    p_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (cmp_rd_valid && !cmp_rd_ready) |=> cmp_rd_valid && $stable(cmp_rd_data));

    p_pcm_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (pcm_rd_valid && !pcm_rd_ready) |=> pcm_rd_valid && $stable(pcm_rd_data));

endmodule

bind host_byte_port hbp_port_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .host_wr     (host_wr),
    .host_addr   (host_addr),
    .cmp_block   (cmp_block),
    .pcm_block   (pcm_block),
    .cmp_busy    (cmp_busy),
    .pcm_busy    (pcm_busy),
    .cmp_ovf     (cmp_ovf),
    .pcm_ovf     (pcm_ovf),
    .cmp_rd_valid(cmp_rd_valid),
    .cmp_rd_ready(cmp_rd_ready),
    .cmp_rd_data (cmp_rd_data),
    .pcm_rd_valid(pcm_rd_valid),
    .pcm_rd_ready(pcm_rd_ready),
    .pcm_rd_data (pcm_rd_data),
    .cmp_cnt     (cmp_cnt),
    .pcm_cnt     (pcm_cnt)
);

// File: tb/host_byte_port_test.sv
module host_byte_port_test;

    localparam int DEPTH = 8;
    localparam int CW    = $clog2(DEPTH + 1);

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          host_wr = 1'b0;
    logic [1:0]    host_addr = '0;
    logic [7:0]    host_data = '0;
    logic          strobe_mode = 1'b0;
    logic          cap_clk = 1'b0;
    logic [7:0]    cap_data = '0;
    logic [CW-1:0] cmp_block = '0;
    logic [CW-1:0] pcm_block = '0;
    logic          cmp_busy, cmp_req, pcm_busy, cmp_ovf, pcm_ovf;
    logic          cmp_rd_valid, pcm_rd_valid;
    logic          cmp_rd_ready = 1'b0;
    logic          pcm_rd_ready = 1'b0;
    logic [7:0]    cmp_rd_data, pcm_rd_data;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    host_byte_port #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_data(host_data), .strobe_mode(strobe_mode), .cap_clk(cap_clk),
        .cap_data(cap_data), .cmp_block(cmp_block), .pcm_block(pcm_block),
        .cmp_busy(cmp_busy), .cmp_req(cmp_req), .pcm_busy(pcm_busy),
        .cmp_ovf(cmp_ovf), .pcm_ovf(pcm_ovf),
        .cmp_rd_valid(cmp_rd_valid), .cmp_rd_ready(cmp_rd_ready), .cmp_rd_data(cmp_rd_data),
        .pcm_rd_valid(pcm_rd_valid), .pcm_rd_ready(pcm_rd_ready), .pcm_rd_data(pcm_rd_data)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        host_wr = 1'b1; host_addr = a; host_data = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic cap_pulse(input logic [7:0] d, input int high_cycles);
        cap_data = d; cap_clk = 1'b1;
        repeat (high_cycles) @(negedge clk);
        cap_clk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic cmp_pop(input string req, input logic [7:0] exp);
        chk(req, int'(cmp_rd_valid), 1);
        chk(req, int'(cmp_rd_data), int'(exp));
        cmp_rd_ready = 1'b1;
        @(negedge clk);
        cmp_rd_ready = 1'b0;
    endtask

    initial begin
        #1500000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        do_reset();
        // R9: reset state
        chk("R9 cmp valid", int'(cmp_rd_valid), 0);
        chk("R9 pcm valid", int'(pcm_rd_valid), 0);
        chk("R9 cmp ovf", int'(cmp_ovf), 0);
        chk("R9 pcm ovf", int'(pcm_ovf), 0);

        // R3 R4 R5: sweep occupancy against block size
        for (int b = 0; b <= DEPTH + 1; b++) begin
            for (int k = 0; k <= DEPTH; k++) begin
                cmp_block = CW'(b);
                pcm_block = CW'(DEPTH + 1 - b);
                do_reset();
                for (int i = 0; i < k; i++) bus_write(2'b11, 8'(i));
                for (int i = 0; i < DEPTH - k; i++) bus_write(2'b10, 8'(i));
                chk("R3 cmp_busy", int'(cmp_busy), int'((k + b) > DEPTH));
                chk("R4 cmp_req", int'(cmp_req), int'(cmp_busy));
                chk("R5 pcm_busy", int'(pcm_busy), int'((DEPTH - k + DEPTH + 1 - b) > DEPTH));
            end
        end

        // R3: indicator rises mid-block and falls after a pop
        cmp_block = CW'(4);
        do_reset();
        for (int i = 0; i < 4; i++) bus_write(2'b11, 8'(i));
        chk("R3 before crossing", int'(cmp_busy), 0);
        bus_write(2'b11, 8'h44);
        chk("R3 rises mid-block", int'(cmp_busy), 1);
        cmp_pop("R3 pop", 8'h00);
        chk("R3 falls after pop", int'(cmp_busy), 0);

        // R1 R7 R8: fill past full, drain in order
        do_reset();
        for (int i = 0; i < DEPTH + 2; i++) bus_write(2'b11, 8'(8'h10 + i));
        chk("R7 cmp ovf set", int'(cmp_ovf), 1);
        chk("R7 pcm ovf clear", int'(pcm_ovf), 0);
        // R7: push into full buffer with simultaneous pop is dropped
        host_wr = 1'b1; host_addr = 2'b11; host_data = 8'hEE; cmp_rd_ready = 1'b1;
        @(negedge clk);
        host_wr = 1'b0; cmp_rd_ready = 1'b0;
        repeat (3) @(negedge clk);
        chk("R8 stalled data", int'(cmp_rd_data), 8'h11);
        for (int i = 1; i < DEPTH; i++) cmp_pop("R1 R8 drain order", 8'(8'h10 + i));
        chk("R7 drop with pop", int'(cmp_rd_valid), 0);
        chk("R7 ovf sticky", int'(cmp_ovf), 1);
        do_reset();
        chk("R9 ovf cleared", int'(cmp_ovf), 0);

        // R2: PCM address and ignored addresses
        bus_write(2'b00, 8'h01);
        bus_write(2'b01, 8'h02);
        chk("R2 addr 0x cmp", int'(cmp_rd_valid), 0);
        chk("R2 addr 0x pcm", int'(pcm_rd_valid), 0);
        bus_write(2'b10, 8'h77);
        bus_write(2'b10, 8'h78);
        chk("R2 pcm valid", int'(pcm_rd_valid), 1);
        chk("R2 pcm data", int'(pcm_rd_data), 8'h77);
        chk("R2 cmp untouched", int'(cmp_rd_valid), 0);
        pcm_rd_ready = 1'b1;
        @(negedge clk);
        pcm_rd_ready = 1'b0;
        chk("R2 pcm second", int'(pcm_rd_data), 8'h78);

        // R6: strobe mode
        strobe_mode = 1'b1;
        do_reset();
        bus_write(2'b11, 8'hAA);
        repeat (3) @(negedge clk);
        chk("R6 bus ignored", int'(cmp_rd_valid), 0);
        cap_pulse(8'h5A, 1);
        cap_pulse(8'hA5, 6);
        cmp_pop("R6 first capture", 8'h5A);
        cmp_pop("R6 held high once", 8'hA5);
        chk("R6 no extra push", int'(cmp_rd_valid), 0);
        strobe_mode = 1'b0;

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule